// File: doc/BRIEF.md
# Triggered Circular-Buffer Capture Core

This block is the capture engine of an embedded logic analyser. Once armed, it writes one sample of a parallel data bus into an on-chip ring memory on every clock. It also watches a separate trigger bus against a programmable value and a per-bit care mask. When the trigger matches, the core records a programmable number of further samples and then stops by itself. At that point the write position is frozen in a stop counter.

A host reaches the core through a 32-bit WISHBONE slave using word addressing. The lower half of the address space returns the sample memory, with several samples packed into each 32-bit word. The upper half holds a small set of control registers. To rebuild the trace in time order, the host reads the whole memory and then rotates it so that the entry at the stop counter comes first.

Top module: `la_capture_core`

## Requirements
- R1: After reset the core is idle. Reads return: status 0, stop counter 0, trigger value 0, care mask 0 and post-trigger length DEPTH/2 (256 with defaults).
- R2: Writing the status register with bit 7 set arms the core. This sets run (status bit 7), clears done (status bit 6) and restarts the write pointer at address 0. A status write with bit 7 clear does not arm the core.
- R3: While running, the core writes the sample present at each rising clock edge to the write-pointer address, then advances the pointer by one. The pointer wraps from DEPTH-1 to 0.
- R4: The trigger matches on a clock edge when every trigger bit whose care bit is 1 equals the matching trigger-value bit. Bits with care 0 are ignored, so an all-zero mask matches on the first running edge.
- R5: The first matching sample while running is stored, followed by exactly N more samples, where N is the post-trigger length. The core then clears run, sets done (status reads 0x40) and loads the stop counter with the address after the last stored sample, modulo DEPTH.
- R6: Memory word w returns 32/DATA_W samples. Lane j, at bits j*DATA_W upward, holds the sample at address w*(32/DATA_W)+j.
- R7: Word addresses with the top address bit 0 select memory words. With the top bit 1, the low three bits select a register: 0 status, 1 stop counter, 2 trigger value, 3 care mask, 4 post-trigger length. Indices 5 to 7 read 0. Status bits 31:8 and bits 5:0 always read 0.
- R8: Bus writes to memory words and to the stop counter have no effect, and the done bit cannot be written.
- R9: A request (CYC and STB high while ACK is low) is acknowledged on the next clock for exactly one cycle, with read data valid alongside. ACK is never high on two consecutive cycles.
- R10: Once capture has stopped, the stop counter and the stored samples stay unchanged until the core is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for sampling and bus access |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W-log2(32/DATA_W)+1 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ACK |
| wb_ack_o | output | 1 | Acknowledge |
| smp_i | input | DATA_W | Sampled data bus |
| trg_i | input | TRIG_W | Trigger bus |

## Verification
The hardest situation to reach from the ports is a capture that wraps the ring several times, ending at an arbitrary stop position that the host must rotate. A related hard case is a run that finishes within two clocks of arming. The bench drives a free-running count on the sample bus and a scrambled copy of it on the trigger bus. This lets it work out, from the count seen at the arming edge, exactly which sample trips the trigger for any value and mask. Post-trigger lengths range from zero to DEPTH-1, with random masks, so the stop counter and every readable lane can be predicted and compared.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  localparam int BUS_W         = 32;
  localparam int STAT_RUN_BIT  = 7;
  localparam int STAT_DONE_BIT = 6;

  typedef enum logic [2:0] {
    RG_STATUS  = 3'd0,
    RG_STOPPTR = 3'd1,
    RG_TVALUE  = 3'd2,
    RG_TMASK   = 3'd3,
    RG_POSTLEN = 3'd4
  } reg_sel_e;

  function automatic logic [BUS_W-1:0] status_word(input logic run, input logic done);
    logic [BUS_W-1:0] w;
    w = '0;
    w[STAT_RUN_BIT]  = run;
    w[STAT_DONE_BIT] = done;
    return w;
  endfunction
endpackage

// File: rtl/la_trig_match.sv
module la_trig_match #(
  parameter int TRIG_W = 8
) (
  input  logic [TRIG_W-1:0] trg_i,
  input  logic [TRIG_W-1:0] tval_i,
  input  logic [TRIG_W-1:0] tmask_i,
  output logic              hit_o
);
  function automatic logic masked_equal(input logic [TRIG_W-1:0] a,
                                        input logic [TRIG_W-1:0] b,
                                        input logic [TRIG_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  assign hit_o = masked_equal(trg_i, tval_i, tmask_i);

  // R4: an empty mask must always match
  always_comb begin
    if (tmask_i == '0) begin
      p_free_match_r4: assert (hit_o);
    end
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              arm_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] post_len_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wptr_o,
  output logic              run_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] stop_ptr_o,
  output logic              stop_evt_o
);
  logic              run_q, done_q, post_q;
  logic [ADDR_W-1:0] wptr_q, stop_q, remain_q;
  logic              pre_stop, post_stop;

  // named events for the checks below
  assign pre_stop   = run_q && !post_q && hit_i && (post_len_i == '0);
  assign post_stop  = run_q && post_q && (remain_q == ADDR_W'(1));
  assign stop_evt_o = pre_stop || post_stop;
  assign wr_en_o    = run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      post_q   <= 1'b0;
      wptr_q   <= '0;
      stop_q   <= '0;
      remain_q <= '0;
    end else if (arm_i) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      post_q <= 1'b0;
      wptr_q <= '0;
    end else if (run_q) begin
      wptr_q <= wptr_q + 1'b1;
      if (stop_evt_o) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
        post_q <= 1'b0;
        stop_q <= wptr_q + 1'b1;
      end else if (!post_q) begin
        if (hit_i) begin
          post_q   <= 1'b1;
          remain_q <= post_len_i;
        end
      end else begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign wptr_o     = wptr_q;
  assign run_o      = run_q;
  assign done_o     = done_q;
  assign stop_ptr_o = stop_q;

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && !arm_i) |=> (wptr_q == $past(wptr_q) + 1'b1));

  p_stop_marks_next_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_q) |-> (stop_q == wptr_q));

  p_done_follows_stop_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (stop_evt_o && !arm_i) |=> (done_q && !run_q));

  p_frozen_when_idle_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && !arm_i) |=> ($stable(wptr_q) && $stable(stop_q)));

  p_run_done_excl_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !(run_q && done_q));
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter int LANES  = 32 / DATA_W,
  parameter int WA_W   = ADDR_W - $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WA_W-1:0]   rword_i,
  output logic [31:0]       rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [ADDR_W-1:0] lane_addr(input logic [WA_W-1:0] w, input int lane);
    return ADDR_W'(w) * ADDR_W'(LANES) + ADDR_W'(lane);
  endfunction

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign rdata_o[j*DATA_W +: DATA_W] = mem[lane_addr(rword_i, j)];
  end
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter int TRIG_W = 8,
  localparam int LANES = 32 / DATA_W,
  localparam int WA_W  = ADDR_W - $clog2(LANES),
  localparam int ADR_W = WA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADR_W-1:0]  wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [TRIG_W-1:0] trg_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              ack_q;
  logic [31:0]       dat_q;
  logic [TRIG_W-1:0] tval_q, tmask_q;
  logic [ADDR_W-1:0] post_q;
  logic              req, sel_regs, wr_cmd, arm;
  reg_sel_e          rsel;
  logic [WA_W-1:0]   word;
  logic [31:0]       rd_mux, mem_word;
  logic              hit, wr_en, run, done, stop_evt;
  logic [ADDR_W-1:0] wptr, stop_ptr;
  logic              unused_wb;

  assign unused_wb = ^wb_dat_i;

  assign req      = wb_cyc_i && wb_stb_i && !ack_q;
  assign sel_regs = wb_adr_i[ADR_W-1];
  assign rsel     = reg_sel_e'(wb_adr_i[2:0]);
  assign word     = wb_adr_i[WA_W-1:0];
  assign wr_cmd   = req && wb_we_i && sel_regs;
  assign arm      = wr_cmd && (rsel == RG_STATUS) && wb_dat_i[STAT_RUN_BIT];

  la_trig_match #(.TRIG_W(TRIG_W)) u_match (
    .trg_i  (trg_i),
    .tval_i (tval_q),
    .tmask_i(tmask_q),
    .hit_o  (hit)
  );

  la_capture_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .arm_i     (arm),
    .hit_i     (hit),
    .post_len_i(post_q),
    .wr_en_o   (wr_en),
    .wptr_o    (wptr),
    .run_o     (run),
    .done_o    (done),
    .stop_ptr_o(stop_ptr),
    .stop_evt_o(stop_evt)
  );

  la_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES), .WA_W(WA_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(wptr),
    .wdata_i(smp_i),
    .rword_i(word),
    .rdata_o(mem_word)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tval_q  <= '0;
      tmask_q <= '0;
      post_q  <= ADDR_W'(DEPTH / 2);
    end else if (wr_cmd) begin
      case (rsel)
        RG_TVALUE:  tval_q  <= wb_dat_i[TRIG_W-1:0];
        RG_TMASK:   tmask_q <= wb_dat_i[TRIG_W-1:0];
        RG_POSTLEN: post_q  <= wb_dat_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!sel_regs) begin
      rd_mux = mem_word;
    end else begin
      case (rsel)
        RG_STATUS:  rd_mux = status_word(run, done);
        RG_STOPPTR: rd_mux = 32'(stop_ptr);
        RG_TVALUE:  rd_mux = 32'(tval_q);
        RG_TMASK:   rd_mux = 32'(tmask_q);
        RG_POSTLEN: rd_mux = 32'(post_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= req;
      if (req) dat_q <= rd_mux;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;

  p_ack_after_req_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

  p_single_ack_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_ack_o |=> !wb_ack_o);

  p_status_clean_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (wb_ack_o && $past(sel_regs && (wb_adr_i[2:0] == 3'd0) && !wb_we_i))
      |-> ((wb_dat_o[31:8] == '0) && (wb_dat_o[5:0] == '0)));

  p_stop_only_on_event_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!stop_evt) |=> $stable(stop_ptr));
endmodule

// File: tb/sim_la_capture_core.sv
module sim_la_capture_core;
  localparam int DW = 16, AW = 9, TW = 8;
  localparam int D = 1 << AW, LN = 32 / DW, WA = AW - 1, ADRW = WA + 1;
  localparam int MEMW = D / LN;
  localparam logic [7:0] SCR = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [ADRW-1:0] adr = '0;
  logic [31:0] wdat = '0, rdat;
  logic ack;
  int cnt = 0;
  logic [DW-1:0] smp;
  logic [TW-1:0] trg;
  int checks = 0, fails = 0, cycles = 0, edge_cnt = 0;
  bit finished = 0;

  assign smp = DW'(cnt);
  assign trg = 8'(cnt) ^ SCR;

  la_capture_core #(.DATA_W(DW), .ADDR_W(AW), .TRIG_W(TW)) u0 (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .smp_i(smp), .trg_i(trg));

  always #2 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: got %0d cycles expected under 190000", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [ADRW-1:0] ra(input int idx);
    return ADRW'(D / LN + idx);
  endfunction

  task automatic xfer(input logic w, input logic [ADRW-1:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    @(negedge clk); cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    @(posedge clk); edge_cnt = cnt;
    @(negedge clk); chk("R9 ack one cycle after request", 32'(ack), 32'd1); q = rdat;
    @(posedge clk);
    @(negedge clk); chk("R9 no back-to-back ack", 32'(ack), 32'd0);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wr(input logic [ADRW-1:0] a, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [ADRW-1:0] a, output logic [31:0] q);
    xfer(1'b0, a, 32'h0, q);
  endtask

  function automatic int first_hit(input int c, input logic [7:0] v, input logic [7:0] m);
    for (int k = 0; k < 1024; k++) begin
      logic [7:0] t;
      bit ok;
      t = 8'(c + k) ^ SCR;
      ok = 1;
      for (int b = 0; b < 8; b++) if (m[b] && (t[b] != v[b])) ok = 0;
      if (ok) return c + k;
    end
    return c;
  endfunction

  task automatic capture_run(input logic [7:0] v, input logic [7:0] m, input int post);
    logic [31:0] q;
    int c0, ch, tot, la, tries;
    wr(ra(2), 32'(v));
    wr(ra(3), 32'(m));
    wr(ra(4), 32'(post));
    wr(ra(0), 32'h80);
    c0 = edge_cnt;
    ch = first_hit(c0 + 1, v, m);
    tot = ch + post - c0;
    rd(ra(0), q);
    chk("R2 status after arm", q, (tot <= 2) ? 32'h40 : 32'h80);
    tries = 0;
    while (q[6] !== 1'b1 && tries < 3000) begin
      rd(ra(0), q); tries++;
    end
    chk("R5 status when stopped", q, 32'h40);
    rd(ra(1), q);
    chk("R5 stop counter", q, 32'(tot % D));
    la = (tot - 1) % D;
    for (int w = 0; w < MEMW; w++) begin
      rd(ADRW'(w), q);
      for (int j = 0; j < LN; j++) begin
        int a;
        a = w * LN + j;
        if (tot >= D || a < tot)
          chk("R3 R4 R6 stored sample", 32'(q[j*DW +: DW]),
              32'(DW'(c0 + tot - ((la - a + D) % D))));
      end
    end
  endtask

  initial begin
    logic [31:0] q, q0, s0;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    rd(ra(0), q); chk("R1 reset status", q, 32'h0);
    rd(ra(1), q); chk("R1 reset stop counter", q, 32'h0);
    rd(ra(2), q); chk("R1 reset trigger value", q, 32'h0);
    rd(ra(3), q); chk("R1 reset care mask", q, 32'h0);
    rd(ra(4), q); chk("R1 reset post length", q, 32'(D / 2));
    wr(ra(0), 32'h7F);
    rd(ra(0), q); chk("R2 write without bit 7 does not arm", q, 32'h0);

    capture_run(8'h00, 8'h00, 0);

    rd(ra(1), s0); rd(16'd0, q0);
    repeat (40) @(posedge clk);
    rd(ra(1), q); chk("R10 stop counter frozen", q, s0);
    rd(16'd0, q); chk("R10 samples frozen", q, q0);
    wr(ADRW'(0), ~q0);
    rd(ADRW'(0), q); chk("R8 memory write ignored", q, q0);
    wr(ra(1), 32'h1A5);
    rd(ra(1), q); chk("R8 stop counter write ignored", q, s0);
    wr(ra(0), 32'h00);
    rd(ra(0), q); chk("R8 done bit not writable", q, 32'h40);
    wr(ra(5), 32'hFFFF_FFFF);
    rd(ra(5), q); chk("R7 unused index reads zero", q, 32'h0);
    wr(ra(2), 32'hFFFF_FF3C);
    rd(ra(2), q); chk("R7 trigger value readback", q, 32'h3C);

    capture_run(8'h10, 8'hFF, 0);
    capture_run(8'h22, 8'hFF, 5);
    capture_run(8'h03, 8'h0F, D - 1);
    capture_run(8'hC7, 8'hFF, 300);
    for (int r = 0; r < 4; r++) begin
      capture_run(8'($urandom), 8'($urandom), int'($urandom % D));
    end
    summary();
  end
endmodule